// File: doc/BRIEF.md
# Latched Level Interrupt Detector

This block sits between a CPU and its external interrupt pins. It takes a set of individual level-sensitive request lines plus one group of encoded priority lines, brings each through a two-flop synchronizer, and keeps a pending flag per source. While holding is switched on, a request that has been seen stays pending after its pin goes inactive. The CPU then sees one interrupt flag and the priority level of the most urgent unmasked source.

Software drives the block through a small register bus with four word addresses. Address 0 sets mask bits, address 1 clears mask bits, address 2 returns the per-source pending status, and address 3 holds the holding-enable bit. A held request is released only by masking the source and then writing its bit to the unmask address. That write also unmasks the source. The mask read-back lets software confirm that the sequence has taken effect. Software is responsible for telling the external device to drop its request before this release.

Source numbering: bits 0..N_PIN-1 are the individual pins and bit N_PIN is the encoded group. Reads are combinational on the address.

Top module: `lvl_irq_detect`

## Requirements
- R1: After reset every mask bit is 1 (0x1F with defaults), status reads 0, holding-enable (address 3, bit 0) reads 1, irq_o is 0 and lvl_o is 0.
- R2: A write to address 0 sets each mask bit whose data bit is 1, and leaves every mask bit whose data bit is 0 unchanged.
- R3: A write to address 1 clears each mask bit whose data bit is 1, and leaves every mask bit whose data bit is 0 unchanged. Addresses 0 and 1 both read back the mask.
- R4: With holding enabled, a pin that is high for at least one clock leaves its status bit (address 2) at 1 after the pin returns low.
- R5: A held request is cleared only by an address-1 write of its bit while its mask bit is 1. The same write on an unmasked source, or an address-0 write alone, leaves the request held.
- R6: With holding disabled (address 3 bit 0 written 0), each status bit follows its synchronized pin, and nothing is latched.
- R7: The encoded group requests when its code differs from all ones, at level equal to the bitwise inverse of the code. Code 1111 is no request.
- R8: irq_o is 1 when any source is both pending and unmasked, and lvl_o then gives the highest level among those sources. When no such source exists, both are 0.
- R9: Individual pin i carries the fixed level 14-2i, which gives 14, 12, 10 and 8 for pins 0 to 3.
- R10: A pin change reaches the status register two clocks after it is applied and reaches irq_o/lvl_o after three clocks, which is inside the 8-clock limit.
- R11: If a source's pin is still active when the clear sequence runs, the request latches again and stays pending after the pin drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_req_i | input | N_PIN | Individual level requests, active high |
| enc_req_i | input | LVL_W | Encoded group code, all ones means idle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| irq_o | output | 1 | Unmasked request pending |
| lvl_o | output | LVL_W | Highest unmasked pending level |

## Verification
The in-line assertions check these rules on every clock: the mask set and clear rules bit by bit, the capture, hold and release of each latch, the rule that the latch is forced clear while holding is off, and the rule that a zero interrupt flag comes with a zero level. Other behaviour shows up only in the bench scenarios. These cover the exact pin-to-output latency, the level ordering when pin and encoded requests compete, the latched level of the encoded group after its code returns idle, and the re-latch that follows when a clear runs while the pin is still active.

// File: rtl/lid_pkg.sv
package lid_pkg;

    localparam int LVL_W = 4;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        REG_MASK   = 2'd0,
        REG_UNMASK = 2'd1,
        REG_STAT   = 2'd2,
        REG_CTRL   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic req;
        lvl_t lvl;
    } src_req_t;

    // Fixed priority of individual pin i
    function automatic lvl_t pin_level(input int idx);
        return lvl_t'(14 - 2 * idx);
    endfunction

    // Encoded group: all ones is idle, otherwise level is the inverted code
    function automatic src_req_t enc_decode(input lvl_t code);
        src_req_t r;
        r.req = (code != '1);
        r.lvl = ~code;
        return r;
    endfunction

endpackage

// File: rtl/lid_sync.sv
module lid_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/lid_hold.sv
module lid_hold
    import lid_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold_en_i,
    input  logic     clr_i,
    input  src_req_t live_i,
    output src_req_t pend_o
);

    logic held_q;
    lvl_t held_lvl_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i || !hold_en_i) begin
            held_q     <= 1'b0;
            held_lvl_q <= '0;
        end else if (live_i.req && !held_q) begin
            held_q     <= 1'b1;
            held_lvl_q <= live_i.lvl;
        end
    end

    always_comb begin
        pend_o.req = live_i.req | held_q;
        if (live_i.req)
            pend_o.lvl = live_i.lvl;
        else if (held_q)
            pend_o.lvl = held_lvl_q;
        else
            pend_o.lvl = '0;
    end

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (hold_en_i && live_i.req && !clr_i) |=> held_q);

    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (hold_en_i && held_q && !clr_i) |=> (held_q && $stable(held_lvl_q)));

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !held_q);

    p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        !hold_en_i |=> !held_q);

endmodule

// File: rtl/lid_prio.sv
module lid_prio
    import lid_pkg::*;
#(
    parameter int N = 5
) (
    input  src_req_t [N-1:0] req_i,
    input  logic [N-1:0]     mask_i,
    output logic             irq_o,
    output lvl_t             lvl_o
);

    always_comb begin
        irq_o = 1'b0;
        lvl_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i].req && !mask_i[i]) begin
                irq_o = 1'b1;
                if (req_i[i].lvl > lvl_o)
                    lvl_o = req_i[i].lvl;
            end
        end
    end

endmodule

// File: rtl/lvl_irq_detect.sv
module lvl_irq_detect
    import lid_pkg::*;
#(
    parameter int N_PIN = 4,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_PIN-1:0] pin_req_i,
    input  logic [LVL_W-1:0] enc_req_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic             irq_o,
    output logic [LVL_W-1:0] lvl_o
);

    localparam int N_SRC   = N_PIN + 1;
    localparam int ENC_IDX = N_PIN;

    logic [N_PIN-1:0]        pin_s;
    lvl_t                    enc_s;
    src_req_t [N_SRC-1:0]    live;
    src_req_t [N_SRC-1:0]    pend;
    logic [N_SRC-1:0]        stat;
    logic [N_SRC-1:0]        mask_q;
    logic [N_SRC-1:0]        mask_d;
    logic [N_SRC-1:0]        clr;
    logic [N_SRC-1:0]        wbits;
    logic                    hold_en_q;
    logic                    wr_mask;
    logic                    wr_unmask;
    logic                    wr_ctrl;
    logic                    irq_d;
    lvl_t                    lvl_d;
    logic                    irq_q;
    lvl_t                    lvl_q;
    logic                    unused_wdata;

    assign unused_wdata = ^wdata_i[DW-1:N_SRC];

    // Input synchronizers
    lid_sync #(.W(N_PIN), .RST_VAL('0)) u_pin_sync (
        .clk (clk), .rst (rst), .d_i (pin_req_i), .q_o (pin_s)
    );

    lid_sync #(.W(LVL_W), .RST_VAL('1)) u_enc_sync (
        .clk (clk), .rst (rst), .d_i (enc_req_i), .q_o (enc_s)
    );

    // Register bus decode
    assign wbits     = wdata_i[N_SRC-1:0];
    assign wr_mask   = wr_en_i && (addr_i == REG_MASK);
    assign wr_unmask = wr_en_i && (addr_i == REG_UNMASK);
    assign wr_ctrl   = wr_en_i && (addr_i == REG_CTRL);

    // Release only on unmask of a currently masked source
    assign clr = wr_unmask ? (wbits & mask_q) : '0;

    always_comb begin
        mask_d = mask_q;
        if (wr_mask)
            mask_d = mask_d | wbits;
        if (wr_unmask)
            mask_d = mask_d & ~wbits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '1;
            hold_en_q <= 1'b1;
        end else begin
            mask_q <= mask_d;
            if (wr_ctrl)
                hold_en_q <= wdata_i[0];
        end
    end

    // Per-source live request and hold latch
    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            if (i == ENC_IDX) begin : g_enc
                assign live[i] = enc_decode(enc_s);
            end else begin : g_pin
                assign live[i] = '{req: pin_s[i], lvl: pin_level(i)};
            end

            lid_hold u_hold (
                .clk       (clk),
                .rst       (rst),
                .hold_en_i (hold_en_q),
                .clr_i     (clr[i]),
                .live_i    (live[i]),
                .pend_o    (pend[i])
            );

            assign stat[i] = pend[i].req;
        end
    endgenerate

    lid_prio #(.N(N_SRC)) u_prio (
        .req_i  (pend),
        .mask_i (mask_q),
        .irq_o  (irq_d),
        .lvl_o  (lvl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            lvl_q <= '0;
        end else begin
            irq_q <= irq_d;
            lvl_q <= lvl_d;
        end
    end

    assign irq_o = irq_q;
    assign lvl_o = lvl_q;

    always_comb begin
        case (addr_i)
            REG_MASK, REG_UNMASK: rdata_o = DW'(mask_q);
            REG_STAT:             rdata_o = DW'(stat);
            default:              rdata_o = DW'(hold_en_q);
        endcase
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && hold_en_q && !irq_o && lvl_o == '0));

    p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> ((mask_q & $past(wbits)) == $past(wbits)));

    p_unmask_r3: assert property (@(posedge clk) disable iff (rst)
        wr_unmask |=> ((mask_q & $past(wbits)) == '0));

    p_unmask_other_r3: assert property (@(posedge clk) disable iff (rst)
        wr_unmask |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits))));

    p_quiet_level_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (lvl_o == '0));

    p_all_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |=> !irq_o);

endmodule

// File: tb/lvl_irq_detect_test.sv
`timescale 1ns/1ps
module lvl_irq_detect_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin_req_i = '0;
    logic [3:0] enc_req_i = 4'hF;
    logic       wr_en_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;
    logic [3:0] lvl_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit         is_reg;
        logic [7:0] exp_d;
        logic       exp_irq;
        logic [3:0] exp_lvl;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #2.5 clk = ~clk;

    lvl_irq_detect uut (
        .clk       (clk),
        .rst       (rst),
        .pin_req_i (pin_req_i),
        .enc_req_i (enc_req_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .irq_o     (irq_o),
        .lvl_o     (lvl_o)
    );

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (it.is_reg) begin
                if (rdata_o !== it.exp_d) begin
                    errors++;
                    $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata_o, it.exp_d);
                end
            end else if (irq_o !== it.exp_irq || lvl_o !== it.exp_lvl) begin
                errors++;
                $display("FAIL %s: irq/lvl actual %b/%0d expected %b/%0d",
                         it.tag, irq_o, lvl_o, it.exp_irq, it.exp_lvl);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk);
        #1;
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(posedge clk);
        #1;
        wr_en_i = 1'b0;
    endtask

    task automatic exp_reg(input logic [1:0] a, input logic [7:0] d, input string tag);
        item_t it;
        addr_i    = a;
        it.is_reg = 1'b1;
        it.exp_d  = d;
        it.exp_irq = 1'b0;
        it.exp_lvl = '0;
        it.tag    = tag;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    task automatic exp_out(input logic irq, input logic [3:0] lvl, input string tag);
        item_t it;
        it.is_reg  = 1'b0;
        it.exp_d   = '0;
        it.exp_irq = irq;
        it.exp_lvl = lvl;
        it.tag     = tag;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);

        // Reset state
        exp_reg(2'd0, 8'h1F, "R1 mask after reset");
        exp_reg(2'd2, 8'h00, "R1 status after reset");
        exp_reg(2'd3, 8'h01, "R1 hold enable after reset");
        exp_out(1'b0, 4'd0, "R1 outputs after reset");

        // Mask set / clear rules
        wr(2'd0, 8'h00);
        exp_reg(2'd0, 8'h1F, "R2 zero write to set keeps mask");
        wr(2'd1, 8'h01);
        exp_reg(2'd1, 8'h1E, "R3 unmask bit 0");
        wr(2'd1, 8'h00);
        exp_reg(2'd0, 8'h1E, "R3 zero write to clear keeps mask");
        wr(2'd0, 8'h01);
        exp_reg(2'd0, 8'h1F, "R2 set bit 0");
        wr(2'd1, 8'h1F);
        wr(2'd0, 8'h02);
        exp_reg(2'd0, 8'h02, "R2 set bit 1 only");
        wr(2'd1, 8'h1F);
        exp_reg(2'd1, 8'h00, "R3 unmask all");

        // Pin 0 latency and hold
        pin_req_i[0] = 1'b1;
        tick(2);
        exp_reg(2'd2, 8'h01, "R10 status two clocks after pin");
        tick(1);
        exp_out(1'b1, 4'd14, "R10 R9 output three clocks after pin");
        pin_req_i[0] = 1'b0;
        tick(4);
        exp_reg(2'd2, 8'h01, "R4 held after pin low");
        exp_out(1'b1, 4'd14, "R4 output held");

        // Release sequence
        wr(2'd1, 8'h01);
        tick(2);
        exp_reg(2'd2, 8'h01, "R5 unmask of unmasked source keeps hold");
        wr(2'd0, 8'h01);
        exp_reg(2'd2, 8'h01, "R5 mask alone keeps hold");
        tick(1);
        exp_out(1'b0, 4'd0, "R8 masked held source gives no irq");
        wr(2'd1, 8'h01);
        exp_reg(2'd2, 8'h00, "R5 mask then unmask clears hold");
        exp_reg(2'd0, 8'h00, "R5 mask cleared by sequence");
        tick(1);
        exp_out(1'b0, 4'd0, "R5 outputs after release");

        // Encoded group and priority
        enc_req_i = 4'b1010;
        tick(3);
        exp_out(1'b1, 4'd5, "R7 encoded level is inverted code");
        exp_reg(2'd2, 8'h10, "R7 encoded status bit");
        pin_req_i[1] = 1'b1;
        tick(3);
        exp_out(1'b1, 4'd12, "R8 highest level wins");
        wr(2'd0, 8'h02);
        tick(1);
        exp_out(1'b1, 4'd5, "R8 masked pin drops out of level");
        enc_req_i = 4'hF;
        tick(3);
        exp_reg(2'd2, 8'h12, "R7 all ones code leaves held status");
        exp_out(1'b1, 4'd5, "R4 encoded level held");
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h10);
        exp_reg(2'd2, 8'h02, "R5 encoded hold released");
        tick(1);
        exp_out(1'b0, 4'd0, "R8 only masked source pending");
        wr(2'd1, 8'h02);
        exp_reg(2'd2, 8'h02, "R11 live pin keeps status");
        tick(1);
        exp_out(1'b1, 4'd12, "R11 unmasked live pin");
        pin_req_i[1] = 1'b0;
        tick(3);
        exp_reg(2'd2, 8'h02, "R11 relatched after pin drops");
        exp_out(1'b1, 4'd12, "R11 relatched output");
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h02);
        exp_reg(2'd2, 8'h00, "R5 second release clears");
        tick(1);
        exp_out(1'b0, 4'd0, "R5 idle after second release");

        // Holding disabled
        wr(2'd3, 8'h00);
        exp_reg(2'd3, 8'h00, "R6 hold disabled readback");
        pin_req_i[2] = 1'b1;
        tick(2);
        exp_reg(2'd2, 8'h04, "R6 status follows pin high");
        tick(1);
        exp_out(1'b1, 4'd10, "R9 pin 2 level");
        pin_req_i[2] = 1'b0;
        tick(2);
        exp_reg(2'd2, 8'h00, "R6 status follows pin low");
        tick(1);
        exp_out(1'b0, 4'd0, "R6 no latch output");
        enc_req_i = 4'b1110;
        tick(3);
        exp_out(1'b1, 4'd1, "R7 code 1110 gives level 1");
        enc_req_i = 4'hF;
        tick(3);
        exp_out(1'b0, 4'd0, "R6 R7 encoded not latched");

        // One-clock pulse captured with holding on
        wr(2'd3, 8'h01);
        pin_req_i[3] = 1'b1;
        tick(1);
        pin_req_i[3] = 1'b0;
        tick(4);
        exp_reg(2'd2, 8'h08, "R4 single clock pulse held");
        exp_out(1'b1, 4'd8, "R9 pin 3 level");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule